// File: doc/BRIEF.md
# Pipeline Hazard and Branch Steering Control

This block is the control unit that keeps a five-stage in-order integer pipeline correct. The five stages are fetch, decode, execute, memory and writeback. Each cycle it looks at the register fields and the load and write-enable flags of the instructions in decode, execute, memory and writeback. From these it drives the operand bypass selects for execute and the bypass select for the branch comparator in decode. It also decides when decode has to hold and push a no-op into execute.

Conditional branches test one source register for zero or non-zero. That test and the target adder both sit in decode, so the datapath hands the block a resolved taken/not-taken flag while the branch is still in decode. A static policy input chooses how the slot behind a branch is handled. The block then produces a squash for the instruction just fetched and a select for the next fetch address. It also holds one valid bit for each pipeline register behind fetch, and these bits show where bubbles and squashed slots travel.

Top module: `pipe_hazard_ctrl`

## Requirements
- R1: While reset is low at a clock edge, all four stage valid bits clear. With idle inputs the block then drives stall 0, flush 0 and next-PC select sequential (00).
- R2: Each execute operand select is 01 when the valid memory-stage instruction writes that register. It is 10 when only the valid writeback-stage instruction writes it, and 00 otherwise. When both stages match, the memory stage wins.
- R3: Register 0 never produces a non-zero bypass select and never causes a stall.
- R4: When the valid decode instruction reads a register that a valid load in execute writes, stall is 1 for exactly one cycle and next-PC select is hold (10). The execute valid bit is 0 on the following cycle.
- R5: When a decode instruction depends on a non-load result still in execute, memory or writeback, the value is bypassed and stall stays 0.
- R6: A branch whose test register is written by an ALU op in execute stalls one cycle. One written by a load in execute stalls two cycles. The branch bypass select is 01 for a non-load result in memory and 10 for a result in writeback.
- R7: Policy 00 (and 11) holds fetch one cycle after every branch in decode: flush is 1, and next-PC select is target (01) if taken or hold (10) if not taken.
- R8: Policy 01 predicts not-taken. A not-taken branch gives flush 0 and select sequential. A taken branch gives flush 1 and select target.
- R9: Policy 10 is a one-slot delayed branch. Flush is never asserted, the select is target when taken, and the slot instruction stays valid in decode.
- R10: When stall and a branch redirect coincide, stall wins: flush is 0 and next-PC select is hold.
- R11: Valid bits advance decode to execute to memory to writeback each cycle, with decode loaded from the fetch-valid input. A flush clears the decode bit on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| policy | input | 2 | Branch policy: 00 hold, 01 predict not-taken, 10 delayed, 11 hold |
| if_valid | input | 1 | Fetch has produced an instruction this cycle |
| id_rs1 | input | 5 | Decode first source register (also branch test register) |
| id_rs2 | input | 5 | Decode second source register |
| id_use_rs1 | input | 1 | Decode instruction reads id_rs1 |
| id_use_rs2 | input | 1 | Decode instruction reads id_rs2 |
| id_is_branch | input | 1 | Decode instruction is a conditional branch |
| id_br_taken | input | 1 | Zero/non-zero test outcome from decode |
| ex_rs1 | input | 5 | Execute first source register |
| ex_rs2 | input | 5 | Execute second source register |
| ex_rd | input | 5 | Execute destination register |
| ex_we | input | 1 | Execute instruction writes ex_rd |
| ex_is_load | input | 1 | Execute instruction is a load |
| mem_rd | input | 5 | Memory-stage destination register |
| mem_we | input | 1 | Memory-stage instruction writes mem_rd |
| mem_is_load | input | 1 | Memory-stage instruction is a load |
| wb_rd | input | 5 | Writeback destination register |
| wb_we | input | 1 | Writeback instruction writes wb_rd |
| fwd_a | output | 2 | Execute operand A bypass select |
| fwd_b | output | 2 | Execute operand B bypass select |
| fwd_br | output | 2 | Branch comparator bypass select |
| stall | output | 1 | Hold fetch and decode, bubble into execute |
| flush_if | output | 1 | Squash the instruction just fetched |
| pc_sel | output | 2 | Next PC: 00 sequential, 01 target, 10 hold |
| stage_vld | output | 4 | Valid bits: bit0 decode, bit1 execute, bit2 memory, bit3 writeback |

## Verification
Some rules are checked on every cycle by the bound checker. Stall must beat any redirect. A stall must be followed by an empty execute slot, and a flush by an empty decode slot. Register 0 must never be bypassed. The delayed policy must never squash, and the two squashing policies must pair their squash with the right next-PC choice. Other behaviour can only be shown by the directed scenarios. These are the memory-over-writeback bypass priority and the exact length of each stall: one cycle for load-use, one cycle for an ALU op feeding a branch, and two cycles for a load feeding a branch. The scenarios also show how valid bits refill after reset.

// File: rtl/hzd_pkg.sv
// Package: shared encodings for the pipeline hazard controller.
// Assumes 2-bit codes for policy, next-PC select and bypass select.
package hzd_pkg;
    localparam int NSTG = 4;  // pipeline registers behind fetch

    typedef enum logic [1:0] {
        POL_HOLD  = 2'b00,
        POL_PNT   = 2'b01,
        POL_DELAY = 2'b10,
        POL_HOLD2 = 2'b11
    } pol_e;

    typedef enum logic [1:0] {
        PC_SEQ  = 2'b00,
        PC_TGT  = 2'b01,
        PC_HOLD = 2'b10
    } pcsel_e;

    typedef enum logic [1:0] {
        FW_NONE = 2'b00,
        FW_MEM  = 2'b01,
        FW_WB   = 2'b10
    } fwd_e;
endpackage

// File: rtl/hzd_fwd_pick.sv
// Bypass picker for one source operand.
// Prefers the memory-stage result over the writeback result; register 0
// is never bypassed. Caller qualifies m_ok/w_ok with valid and write flags.
module hzd_fwd_pick
    import hzd_pkg::*;
#(
    parameter int RW = 5
) (
    input  logic [RW-1:0] src,
    input  logic          req,
    input  logic [RW-1:0] m_rd,
    input  logic          m_ok,
    input  logic [RW-1:0] w_rd,
    input  logic          w_ok,
    output logic [1:0]    sel
);
    // Choose the youngest in-flight producer of src
    always_comb begin
        sel = FW_NONE;
        if (req && src != '0) begin
            if (m_ok && m_rd == src)      sel = FW_MEM;
            else if (w_ok && w_rd == src) sel = FW_WB;
        end
    end
endmodule

// File: rtl/hzd_stall_det.sv
// Stall detector for decode.
// Raises stall for load-use on either source, and for a branch whose test
// register is not yet available to the decode comparator (producer in
// execute, or a load in memory). Register 0 is never a hazard.
module hzd_stall_det #(
    parameter int RW = 5
) (
    input  logic          vld_d,
    input  logic          vld_x,
    input  logic          vld_m,
    input  logic [RW-1:0] id_rs1,
    input  logic [RW-1:0] id_rs2,
    input  logic          id_use_rs1,
    input  logic          id_use_rs2,
    input  logic          id_is_branch,
    input  logic [RW-1:0] ex_rd,
    input  logic          ex_we,
    input  logic          ex_is_load,
    input  logic [RW-1:0] mem_rd,
    input  logic          mem_is_load,
    output logic          stall
);
    logic load_use, br_on_ex, br_on_mem_ld;

    function automatic logic hit(input logic [RW-1:0] a, input logic [RW-1:0] b);
        return (a != '0) && (a == b);
    endfunction

    // Combine the three hazard classes
    always_comb begin
        load_use = vld_d && vld_x && ex_is_load &&
                   ((id_use_rs1 && hit(id_rs1, ex_rd)) ||
                    (id_use_rs2 && hit(id_rs2, ex_rd)));
        br_on_ex = vld_d && id_is_branch && vld_x &&
                   (ex_we || ex_is_load) && hit(id_rs1, ex_rd);
        br_on_mem_ld = vld_d && id_is_branch && vld_m &&
                       mem_is_load && hit(id_rs1, mem_rd);
        stall = load_use || br_on_ex || br_on_mem_ld;
    end
endmodule

// File: rtl/hzd_steer.sv
// Branch steering: squash and next-PC select per branch policy.
// Assumes the branch outcome is resolved in decode; stall overrides all.
module hzd_steer
    import hzd_pkg::*;
(
    input  logic [1:0] policy,
    input  logic       br_live,
    input  logic       taken,
    input  logic       stall,
    output logic       flush_if,
    output logic [1:0] pc_sel
);
    // Policy-dependent squash and redirect
    always_comb begin
        flush_if = 1'b0;
        pc_sel   = PC_SEQ;
        if (stall) begin
            pc_sel = PC_HOLD;
        end else if (br_live) begin
            case (pol_e'(policy))
                POL_PNT: begin
                    flush_if = taken;
                    pc_sel   = taken ? PC_TGT : PC_SEQ;
                end
                POL_DELAY: begin
                    pc_sel = taken ? PC_TGT : PC_SEQ;
                end
                default: begin
                    flush_if = 1'b1;
                    pc_sel   = taken ? PC_TGT : PC_HOLD;
                end
            endcase
        end
    end
endmodule

// File: rtl/hzd_vld_track.sv
// Valid-bit tracker for the pipeline registers behind fetch.
// Bit 0 is decode. A stall holds decode and bubbles execute; a flush
// empties decode. Synchronous active-low reset clears every bit.
module hzd_vld_track #(
    parameter int NS = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          if_valid,
    input  logic          stall,
    input  logic          flush_if,
    output logic [NS-1:0] vld
);
    // Advance valid bits one stage per cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld <= '0;
        end else begin
            vld[0] <= stall ? vld[0] : (if_valid && !flush_if);
            vld[1] <= stall ? 1'b0 : vld[0];
            for (int i = 2; i < NS; i++) begin
                vld[i] <= vld[i-1];
            end
        end
    end
endmodule

// File: rtl/pipe_hazard_ctrl.sv
// Top: hazard detection, operand bypass and branch steering for a
// five-stage in-order pipeline. Assumes branches are resolved in decode
// and the branch test register is the first source.
module pipe_hazard_ctrl
    import hzd_pkg::*;
#(
    parameter int NREGS = 32,
    localparam int RW   = $clog2(NREGS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    policy,
    input  logic          if_valid,
    input  logic [RW-1:0] id_rs1,
    input  logic [RW-1:0] id_rs2,
    input  logic          id_use_rs1,
    input  logic          id_use_rs2,
    input  logic          id_is_branch,
    input  logic          id_br_taken,
    input  logic [RW-1:0] ex_rs1,
    input  logic [RW-1:0] ex_rs2,
    input  logic [RW-1:0] ex_rd,
    input  logic          ex_we,
    input  logic          ex_is_load,
    input  logic [RW-1:0] mem_rd,
    input  logic          mem_we,
    input  logic          mem_is_load,
    input  logic [RW-1:0] wb_rd,
    input  logic          wb_we,
    output logic [1:0]    fwd_a,
    output logic [1:0]    fwd_b,
    output logic [1:0]    fwd_br,
    output logic          stall,
    output logic          flush_if,
    output logic [1:0]    pc_sel,
    output logic [NSTG-1:0] stage_vld
);
    localparam int NFWD = 3;  // operand A, operand B, branch comparator

    logic vld_d, vld_x, vld_m, vld_w;
    logic [RW-1:0] fw_src [NFWD];
    logic [NFWD-1:0] fw_req, fw_mok;
    logic [1:0] fw_sel [NFWD];
    logic w_ok;

    assign vld_d = stage_vld[0];
    assign vld_x = stage_vld[1];
    assign vld_m = stage_vld[2];
    assign vld_w = stage_vld[3];

    // Bypass requesters: two execute operands and the decode comparator
    always_comb begin
        fw_src[0] = ex_rs1;
        fw_src[1] = ex_rs2;
        fw_src[2] = id_rs1;
        fw_req    = {vld_d && id_is_branch, vld_x, vld_x};
        fw_mok[0] = vld_m && mem_we;
        fw_mok[1] = vld_m && mem_we;
        fw_mok[2] = vld_m && mem_we && !mem_is_load;
        w_ok      = vld_w && wb_we;
    end

    for (genvar g = 0; g < NFWD; g++) begin : g_fwd
        hzd_fwd_pick #(.RW(RW)) u_pick (
            .src  (fw_src[g]),
            .req  (fw_req[g]),
            .m_rd (mem_rd),
            .m_ok (fw_mok[g]),
            .w_rd (wb_rd),
            .w_ok (w_ok),
            .sel  (fw_sel[g])
        );
    end

    assign fwd_a  = fw_sel[0];
    assign fwd_b  = fw_sel[1];
    assign fwd_br = fw_sel[2];

    hzd_stall_det #(.RW(RW)) u_stall (
        .vld_d        (vld_d),
        .vld_x        (vld_x),
        .vld_m        (vld_m),
        .id_rs1       (id_rs1),
        .id_rs2       (id_rs2),
        .id_use_rs1   (id_use_rs1),
        .id_use_rs2   (id_use_rs2),
        .id_is_branch (id_is_branch),
        .ex_rd        (ex_rd),
        .ex_we        (ex_we),
        .ex_is_load   (ex_is_load),
        .mem_rd       (mem_rd),
        .mem_is_load  (mem_is_load),
        .stall        (stall)
    );

    hzd_steer u_steer (
        .policy   (policy),
        .br_live  (vld_d && id_is_branch),
        .taken    (id_br_taken),
        .stall    (stall),
        .flush_if (flush_if),
        .pc_sel   (pc_sel)
    );

    hzd_vld_track #(.NS(NSTG)) u_vld (
        .clk      (clk),
        .rst_n    (rst_n),
        .if_valid (if_valid),
        .stall    (stall),
        .flush_if (flush_if),
        .vld      (stage_vld)
    );
endmodule

// File: rtl/pipe_hazard_ctrl_chk.sv
// Checker for pipe_hazard_ctrl: cycle-level control invariants.
// Attached to every instance of the top through bind.
module pipe_hazard_ctrl_chk #(
    parameter int RW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic [1:0]    policy,
    input logic [RW-1:0] ex_rs1,
    input logic [RW-1:0] ex_rs2,
    input logic [RW-1:0] id_rs1,
    input logic [1:0]    fwd_a,
    input logic [1:0]    fwd_b,
    input logic [1:0]    fwd_br,
    input logic          stall,
    input logic          flush_if,
    input logic [1:0]    pc_sel,
    input logic [3:0]    stage_vld
);
    p_stall_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> (!flush_if && pc_sel == 2'b10));

    p_bubble_r4: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> !stage_vld[1]);

    p_no_squash_delay_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (policy == 2'b10) |-> !flush_if);

    p_zero_a_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_a != 2'b00) |-> (ex_rs1 != '0));

    p_zero_b_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_b != 2'b00) |-> (ex_rs2 != '0));

    p_zero_br_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_br != 2'b00) |-> (id_rs1 != '0));

    p_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_a != 2'b11) && (fwd_b != 2'b11));

    p_flush_empties_r11: assert property (@(posedge clk) disable iff (!rst_n)
        flush_if |=> !stage_vld[0]);

    p_shift_r11: assert property (@(posedge clk) disable iff (!rst_n)
        stage_vld[2] |=> stage_vld[3]);

    p_pnt_redirect_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (policy == 2'b01 && flush_if) |-> (pc_sel == 2'b01));

    p_hold_squash_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((policy == 2'b00 || policy == 2'b11) && pc_sel == 2'b01) |-> flush_if);
endmodule

bind pipe_hazard_ctrl pipe_hazard_ctrl_chk #(.RW(RW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .policy    (policy),
    .ex_rs1    (ex_rs1),
    .ex_rs2    (ex_rs2),
    .id_rs1    (id_rs1),
    .fwd_a     (fwd_a),
    .fwd_b     (fwd_b),
    .fwd_br    (fwd_br),
    .stall     (stall),
    .flush_if  (flush_if),
    .pc_sel    (pc_sel),
    .stage_vld (stage_vld)
);

// File: tb/pipe_hazard_ctrl_bench.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario, each checking its own results.
module pipe_hazard_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] policy;
    logic       if_valid;
    logic [4:0] id_rs1, id_rs2, ex_rs1, ex_rs2, ex_rd, mem_rd, wb_rd;
    logic       id_use_rs1, id_use_rs2, id_is_branch, id_br_taken;
    logic       ex_we, ex_is_load, mem_we, mem_is_load, wb_we;
    logic [1:0] fwd_a, fwd_b, fwd_br, pc_sel;
    logic       stall, flush_if;
    logic [3:0] stage_vld;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #4 clk = ~clk;  // 125 MHz

    pipe_hazard_ctrl u_pipe_hazard_ctrl (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Advance one clock; return just after the falling edge
    task automatic step();
        @(posedge clk);
        @(negedge clk);
        #1;
    endtask

    task automatic idle();
        id_rs1 = 0; id_rs2 = 0; id_use_rs1 = 0; id_use_rs2 = 0;
        id_is_branch = 0; id_br_taken = 0;
        ex_rs1 = 0; ex_rs2 = 0; ex_rd = 0; ex_we = 0; ex_is_load = 0;
        mem_rd = 0; mem_we = 0; mem_is_load = 0; wb_rd = 0; wb_we = 0;
    endtask

    // Refill every stage with valid instructions
    task automatic settle();
        idle();
        repeat (4) step();
    endtask

    task automatic t_reset();
        rst_n = 0; if_valid = 0; policy = 2'b00; idle();
        repeat (3) step();
        chk("R1 stage_vld", stage_vld, 4'b0000);
        chk("R1 pc_sel", pc_sel, 2'b00);
        chk("R1 stall", stall, 1'b0);
        chk("R1 flush", flush_if, 1'b0);
    endtask

    task automatic t_fill();
        rst_n = 1; if_valid = 1;
        step();
        chk("R11 fill 1", stage_vld, 4'b0001);
        step(); step(); step();
        chk("R11 fill 4", stage_vld, 4'b1111);
    endtask

    task automatic t_forward();
        settle();
        ex_rs1 = 5; ex_rs2 = 6; mem_rd = 5; mem_we = 1; wb_rd = 6; wb_we = 1;
        #1;
        chk("R2 fwd_a mem", fwd_a, 2'b01);
        chk("R2 fwd_b wb", fwd_b, 2'b10);
        wb_rd = 5; #1;
        chk("R2 mem priority", fwd_a, 2'b01);
        mem_we = 0; #1;
        chk("R2 fwd_a wb only", fwd_a, 2'b10);
        ex_rs1 = 0; mem_rd = 0; mem_we = 1; wb_rd = 0; #1;
        chk("R3 fwd_a r0", fwd_a, 2'b00);
    endtask

    task automatic t_zero_stall();
        settle();
        id_use_rs1 = 1; id_rs1 = 0; ex_rd = 0; ex_we = 1; ex_is_load = 1; #1;
        chk("R3 load r0 stall", stall, 1'b0);
        id_is_branch = 1; ex_is_load = 0; #1;
        chk("R3 branch r0 stall", stall, 1'b0);
    endtask

    task automatic t_alu_nostall();
        settle();
        id_use_rs1 = 1; id_rs1 = 7; ex_rd = 7; ex_we = 1; #1;
        chk("R5 alu stall", stall, 1'b0);
        chk("R5 pc_sel", pc_sel, 2'b00);
    endtask

    task automatic t_load_use();
        settle();
        id_use_rs2 = 1; id_rs2 = 7; ex_rd = 7; ex_we = 1; ex_is_load = 1; #1;
        chk("R4 stall", stall, 1'b1);
        chk("R4 pc hold", pc_sel, 2'b10);
        step();
        chk("R4 ex bubble", stage_vld[1], 1'b0);
        chk("R4 decode held", stage_vld[0], 1'b1);
        ex_rd = 0; ex_we = 0; ex_is_load = 0;
        mem_rd = 7; mem_we = 1; mem_is_load = 1; #1;
        chk("R4 one bubble only", stall, 1'b0);
        chk("R4 pc seq", pc_sel, 2'b00);
        step();
        chk("R11 bubble in mem", stage_vld[2], 1'b0);
    endtask

    task automatic t_branch_dep();
        policy = 2'b10;
        settle();
        id_is_branch = 1; id_rs1 = 9; ex_rd = 9; ex_we = 1; #1;
        chk("R6 alu->br stall", stall, 1'b1);
        step();
        ex_rd = 0; ex_we = 0; mem_rd = 9; mem_we = 1; #1;
        chk("R6 alu->br released", stall, 1'b0);
        chk("R6 fwd_br mem", fwd_br, 2'b01);
        settle();
        id_is_branch = 1; id_rs1 = 9; ex_rd = 9; ex_we = 1; ex_is_load = 1; #1;
        chk("R6 ld->br stall 1", stall, 1'b1);
        step();
        ex_rd = 0; ex_we = 0; ex_is_load = 0; mem_rd = 9; mem_we = 1; mem_is_load = 1; #1;
        chk("R6 ld->br stall 2", stall, 1'b1);
        step();
        mem_rd = 0; mem_we = 0; mem_is_load = 0; wb_rd = 9; wb_we = 1; #1;
        chk("R6 ld->br released", stall, 1'b0);
        chk("R6 fwd_br wb", fwd_br, 2'b10);
    endtask

    task automatic t_pol_hold();
        policy = 2'b00;
        settle();
        id_is_branch = 1; id_rs1 = 3; id_br_taken = 1; #1;
        chk("R7 taken flush", flush_if, 1'b1);
        chk("R7 taken pc", pc_sel, 2'b01);
        id_br_taken = 0; #1;
        chk("R7 untaken flush", flush_if, 1'b1);
        chk("R7 untaken pc hold", pc_sel, 2'b10);
        step();
        chk("R11 flush empties decode", stage_vld[0], 1'b0);
        policy = 2'b11;
        settle();
        id_is_branch = 1; id_rs1 = 3; id_br_taken = 0; #1;
        chk("R7 policy 11 pc hold", pc_sel, 2'b10);
    endtask

    task automatic t_pol_pnt();
        policy = 2'b01;
        settle();
        id_is_branch = 1; id_rs1 = 3; id_br_taken = 0; #1;
        chk("R8 untaken flush", flush_if, 1'b0);
        chk("R8 untaken pc", pc_sel, 2'b00);
        id_br_taken = 1; #1;
        chk("R8 taken flush", flush_if, 1'b1);
        chk("R8 taken pc", pc_sel, 2'b01);
    endtask

    task automatic t_pol_delay();
        policy = 2'b10;
        settle();
        id_is_branch = 1; id_rs1 = 3; id_br_taken = 1; #1;
        chk("R9 taken flush", flush_if, 1'b0);
        chk("R9 taken pc", pc_sel, 2'b01);
        step();
        idle(); #1;
        chk("R9 slot kept", stage_vld[0], 1'b1);
    endtask

    task automatic t_conflict();
        policy = 2'b01;
        settle();
        id_is_branch = 1; id_rs1 = 4; id_br_taken = 1; ex_rd = 4; ex_we = 1; #1;
        chk("R10 stall", stall, 1'b1);
        chk("R10 flush held off", flush_if, 1'b0);
        chk("R10 pc hold", pc_sel, 2'b10);
    endtask

    initial begin
        rst_n = 0; if_valid = 0; policy = 2'b00; idle();
        t_reset();
        t_fill();
        t_forward();
        t_zero_stall();
        t_alu_nostall();
        t_load_use();
        t_branch_dep();
        t_pol_hold();
        t_pol_pnt();
        t_pol_delay();
        t_conflict();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule